// File: doc/BRIEF.md
# Hibernation Power Sequencing Controller

This block sits in an always-powered domain and decides when the chip sleeps and when it comes back. Software writes a hibernate request through a small register port. The controller refuses the request unless a wake source is armed. While a flash write is in flight it defers entry. It then either tells an external regulator to switch off, or, in a retained-supply mode, gates internal power and turns every pin into an input while the supply stays up.

A wake comes from a rising edge on the synchronized wake pin or from an RTC match pulse, and only from the sources that are armed. The controller then waits for a supply-good input, drives a fixed-length reset pulse to the rest of the chip and returns to run. Its own registers are not touched by that pulse. Three events (pin wake, RTC match, low battery) latch into raw status bits, which software clears by writing 1. These bits are masked and combined into one interrupt line.

Top module: `hib_seq_ctrl`

## Requirements
- R1: A hibernate request (write to address 0 with bit 0 set) is ignored, and the block stays in run, when neither bit 1 (pin wake enable) nor bit 2 (RTC wake enable) of that same write is set.
- R2: If `flashBusy` is high when an accepted request arrives, entry is deferred and `regOff` stays low. Entry follows in the cycle after `flashBusy` falls, with no new request.
- R3: With control bit 3 (retain mode) clear, `regOff` is high throughout hibernation and drops on the cycle the wake is taken.
- R4: With control bit 3 set, hibernation raises `powerGate` and `pinsInput` and keeps `regOff` low. Both stay high until the reset pulse starts.
- R5: A wake is taken only from a wake-pin rising edge with bit 1 set, or from an `rtcMatch` pulse with bit 2 set. An unarmed source does not wake the block, but it still sets its raw status bit.
- R6: After a wake, the block holds in a wait state, with no reset pulse and gating released, until `supplyGood` is high.
- R7: Leaving hibernation drives `chipRst` high for exactly 16 cycles and then returns to run. Control, mask and status registers keep their values.
- R8: Address 2 is the mask (bits 2:0). Address 3 reads raw AND mask. `irq` is high whenever any masked bit is set.
- R9: Address 1 reads raw status: bit 0 pin edge, bit 1 RTC match, bit 2 low battery. Writing 1 to a bit at address 4 clears it. An event in the same cycle as the clear wins, and the bit stays set.
- R10: The request bit always reads back as 0. A rejected request sets no status bit.
- R11: A wake-pin rising edge acts on the third rising clock edge after it is applied, through a two-stage synchronizer and an edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset of the always-on domain |
| regAddr | input | 3 | Register address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from address |
| wakePin | input | 1 | Asynchronous external wake pin |
| rtcMatch | input | 1 | RTC match pulse |
| lowBatt | input | 1 | Low-battery indication |
| flashBusy | input | 1 | Flash write in progress |
| supplyGood | input | 1 | Core supply valid |
| regOff | output | 1 | Active-high regulator power-off request |
| powerGate | output | 1 | Internal power gating in retain mode |
| pinsInput | output | 1 | Force all pins to input in retain mode |
| chipRst | output | 1 | Reset pulse to the rest of the chip |
| irq | output | 1 | Combined masked interrupt |

## Verification
A control write takes effect on `regOff` and `powerGate` one edge after it is applied. An RTC match acts one edge later, and a pin edge three edges later. Once a wake is taken with `supplyGood` already high, `chipRst` rises one edge after that. Status and masked reads are combinational from the registers one edge after the event. The bench drives on falling edges and samples at the falling edge after the exact number of rising edges. It checks one edge early where the latency itself is the requirement, and counts reset-pulse cycles one falling edge at a time.

// File: rtl/hib_seq_pkg.sv
package hib_seq_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int EVT_N  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_RAW  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MIS  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd4;

  typedef enum logic [2:0] {
    ST_RUN, ST_PEND, ST_HIB, ST_WAITPWR, ST_RSTPULSE
  } hibState_e;

  typedef struct packed {
    logic hibReq;
    logic wakeHit;
  } seqStrobe_t;
endpackage

// File: rtl/hib_seq_dp.sv
module hib_seq_dp
  import hib_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              wakePin,
  input  logic              rtcMatch,
  input  logic              lowBatt,
  output logic              irq,
  output logic              retainMode,
  output seqStrobe_t        strb
);
  localparam int SMSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] pinSync;
  logic pinPrev, pinEdge;
  logic pinEn, rtcEn;
  logic [EVT_N-1:0] rawStat, maskReg, misStat, evtNow, clrBits;
  logic ctrlWr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinSync <= '0;
      pinPrev <= 1'b0;
    end else begin
      pinSync <= {pinSync[SMSB-1:0], wakePin};
      pinPrev <= pinSync[SMSB];
    end
  end
  assign pinEdge = pinSync[SMSB] & ~pinPrev;

  assign ctrlWr  = regWe && (regAddr == ADDR_CTRL);
  assign clrBits = (regWe && (regAddr == ADDR_CLR)) ? regWdata[EVT_N-1:0] : '0;
  assign evtNow  = {lowBatt, rtcMatch, pinEdge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinEn      <= 1'b0;
      rtcEn      <= 1'b0;
      retainMode <= 1'b0;
      maskReg    <= '0;
      rawStat    <= '0;
    end else begin
      if (ctrlWr) begin
        pinEn      <= regWdata[1];
        rtcEn      <= regWdata[2];
        retainMode <= regWdata[3];
      end
      if (regWe && (regAddr == ADDR_MASK)) maskReg <= regWdata[EVT_N-1:0];
      rawStat <= (rawStat & ~clrBits) | evtNow;
    end
  end

  assign misStat = rawStat & maskReg;
  assign irq     = |misStat;

  assign strb.hibReq  = ctrlWr & regWdata[0] & (regWdata[1] | regWdata[2]);
  assign strb.wakeHit = (pinEdge & pinEn) | (rtcMatch & rtcEn);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: regRdata = {4'b0, retainMode, rtcEn, pinEn, 1'b0};
      ADDR_RAW:  regRdata[EVT_N-1:0] = rawStat;
      ADDR_MASK: regRdata[EVT_N-1:0] = maskReg;
      ADDR_MIS:  regRdata[EVT_N-1:0] = misStat;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/hib_seq_fsm.sv
module hib_seq_fsm
  import hib_seq_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seqStrobe_t strb,
  input  logic       flashBusy,
  input  logic       supplyGood,
  input  logic       retainMode,
  output hibState_e  curState,
  output logic       regOff,
  output logic       powerGate,
  output logic       pinsInput,
  output logic       chipRst
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

  hibState_e nxtState;
  logic [CNT_W-1:0] rstCnt;

  always_comb begin
    nxtState = curState;
    unique case (curState)
      ST_RUN:      if (strb.hibReq) nxtState = flashBusy ? ST_PEND : ST_HIB;
      ST_PEND:     if (!flashBusy) nxtState = ST_HIB;
      ST_HIB:      if (strb.wakeHit) nxtState = ST_WAITPWR;
      ST_WAITPWR:  if (supplyGood) nxtState = ST_RSTPULSE;
      ST_RSTPULSE: if (rstCnt == CNT_LAST) nxtState = ST_RUN;
      default:     nxtState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curState <= ST_RUN;
      rstCnt   <= '0;
    end else begin
      curState <= nxtState;
      if (curState == ST_RSTPULSE) rstCnt <= rstCnt + 1'b1;
      else                         rstCnt <= '0;
    end
  end

  assign regOff    = (curState == ST_HIB) && !retainMode;
  assign powerGate = ((curState == ST_HIB) || (curState == ST_WAITPWR)) && retainMode;
  assign pinsInput = powerGate;
  assign chipRst   = (curState == ST_RSTPULSE);
endmodule

// File: rtl/hib_seq_ctrl.sv
module hib_seq_ctrl
  import hib_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              wakePin,
  input  logic              rtcMatch,
  input  logic              lowBatt,
  input  logic              flashBusy,
  input  logic              supplyGood,
  output logic              regOff,
  output logic              powerGate,
  output logic              pinsInput,
  output logic              chipRst,
  output logic              irq
);
  seqStrobe_t strb;
  logic       retainMode;
  hibState_e  curState;

  hib_seq_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .wakePin(wakePin),
    .rtcMatch(rtcMatch), .lowBatt(lowBatt), .irq(irq),
    .retainMode(retainMode), .strb(strb)
  );

  hib_seq_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .strb(strb), .flashBusy(flashBusy),
    .supplyGood(supplyGood), .retainMode(retainMode), .curState(curState),
    .regOff(regOff), .powerGate(powerGate), .pinsInput(pinsInput),
    .chipRst(chipRst)
  );
endmodule

// File: rtl/hib_seq_chk.sv
module hib_seq_chk
  import hib_seq_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input hibState_e         curState,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [DATA_W-1:0] regWdata,
  input logic              flashBusy,
  input logic              supplyGood,
  input logic              regOff,
  input logic              powerGate,
  input logic              chipRst
);
  logic [15:0] hiCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hiCnt <= '0;
    else if (chipRst) hiCnt <= hiCnt + 1'b1;
    else              hiCnt <= '0;
  end

  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_RUN && regWe && regAddr == ADDR_CTRL && regWdata[0] && regWdata[2:1] == 2'b00)
      |=> (curState == ST_RUN));

  p_flash_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_PEND && flashBusy) |=> (curState == ST_PEND && !regOff));

  p_retain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    powerGate |-> !regOff);

  p_wait_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_WAITPWR && !supplyGood) |=> (curState == ST_WAITPWR && !chipRst));

  p_rst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chipRst) |-> (hiCnt == 16'(RST_CYCLES)));
endmodule

bind hib_seq_ctrl hib_seq_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .curState(curState), .regAddr(regAddr),
  .regWe(regWe), .regWdata(regWdata), .flashBusy(flashBusy),
  .supplyGood(supplyGood), .regOff(regOff), .powerGate(powerGate),
  .chipRst(chipRst)
);

// File: tb/hib_seq_ctrl_tb.sv
module hib_seq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic wakePin = 1'b0, rtcMatch = 1'b0, lowBatt = 1'b0, flashBusy = 1'b0, supplyGood = 1'b1;
  logic regOff, powerGate, pinsInput, chipRst, irq;

  int total = 0;
  int failed = 0;
  int cycles = 0;

  // each entry: {pad, irq, masked[2:0], mask[2:0]} with raw = 3'b111
  localparam logic [7:0] MASK_VEC [8] = '{
    8'h00, 8'h49, 8'h52, 8'h5B, 8'h64, 8'h6D, 8'h76, 8'h7F
  };

  hib_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .wakePin(wakePin),
    .rtcMatch(rtcMatch), .lowBatt(lowBatt), .flashBusy(flashBusy),
    .supplyGood(supplyGood), .regOff(regOff), .powerGate(powerGate),
    .pinsInput(pinsInput), .chipRst(chipRst), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      total = total + 1;
      failed = failed + 1;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total = total + 1;
    if (act !== exp) begin
      failed = failed + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic countRst(output int n);
    n = 0;
    while (chipRst && n < 100) begin
      n = n + 1;
      tick(1);
    end
  endtask

  initial begin
    logic [7:0] d;
    int n;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // reset state
    check("reset regOff", {7'b0, regOff}, 8'h0);
    check("reset gate/rst/irq", {5'b0, powerGate, chipRst, irq}, 8'h0);
    rd(3'd1, d); check("reset raw", d, 8'h00);

    // R1 / R10: request with no wake source
    wr(3'd0, 8'h01);
    tick(5);
    check("R1 rejected request", {6'b0, regOff, powerGate}, 8'h0);
    rd(3'd0, d); check("R10 request bit reads 0", d, 8'h00);
    rd(3'd1, d); check("R10 no status on reject", d, 8'h00);

    // R3 / R5 / R6 / R7 / R11: normal mode, pin wake
    supplyGood = 1'b0;
    wr(3'd0, 8'h03);
    check("R3 regOff in hibernation", {7'b0, regOff}, 8'h1);
    rtcMatch = 1'b1; tick(1); rtcMatch = 1'b0; tick(3);
    check("R5 unarmed rtc no wake", {7'b0, regOff}, 8'h1);
    rd(3'd1, d); check("R5 unarmed rtc sets raw", d, 8'h02);
    wakePin = 1'b1;
    tick(2);
    check("R11 no wake after two edges", {7'b0, regOff}, 8'h1);
    tick(1);
    check("R11 wake on third edge", {7'b0, regOff}, 8'h0);
    tick(5);
    check("R6 waiting for supply", {6'b0, chipRst, powerGate}, 8'h0);
    supplyGood = 1'b1;
    tick(1);
    countRst(n);
    check("R7 reset pulse length", 8'(n), 8'd16);
    rd(3'd0, d); check("R7 control kept", d, 8'h02);
    rd(3'd1, d); check("R9 raw shows pin and rtc", d, 8'h03);
    wakePin = 1'b0;

    // R2: flash busy defers entry
    wr(3'd4, 8'h07);
    flashBusy = 1'b1;
    wr(3'd0, 8'h05);
    tick(4);
    check("R2 deferred while busy", {7'b0, regOff}, 8'h0);
    flashBusy = 1'b0;
    tick(1);
    check("R2 entry after busy falls", {7'b0, regOff}, 8'h1);
    rtcMatch = 1'b1; tick(1); rtcMatch = 1'b0;
    check("R5 rtc wake", {7'b0, regOff}, 8'h0);
    tick(1);
    check("R7 reset begins", {7'b0, chipRst}, 8'h1);
    tick(20);
    check("R7 back to run", {7'b0, chipRst}, 8'h0);

    // R4: retain mode
    wr(3'd0, 8'h0B);
    check("R4 gate and pins", {5'b0, powerGate, pinsInput, regOff}, 8'h06);
    wakePin = 1'b1;
    tick(3);
    check("R4 gating held in wait", {7'b0, powerGate}, 8'h1);
    tick(1);
    check("R4 gating released at reset", {6'b0, powerGate, chipRst}, 8'h01);
    tick(20);
    wakePin = 1'b0;
    tick(2);

    // R8: mask table with all raw bits set
    wr(3'd4, 8'h07);
    wakePin = 1'b1; rtcMatch = 1'b1; lowBatt = 1'b1;
    tick(1);
    rtcMatch = 1'b0; lowBatt = 1'b0;
    tick(3);
    rd(3'd1, d); check("R9 all raw set", d, 8'h07);
    for (int i = 0; i < 8; i++) begin
      wr(3'd2, {5'b0, MASK_VEC[i][2:0]});
      rd(3'd3, d); check("R8 masked status", d, {5'b0, MASK_VEC[i][5:3]});
      check("R8 irq", {7'b0, irq}, {7'b0, MASK_VEC[i][6]});
    end

    // R9: write-1 clear and event priority
    wr(3'd4, 8'h02);
    rd(3'd1, d); check("R9 clear rtc bit", d, 8'h05);
    lowBatt = 1'b1;
    wr(3'd4, 8'h04);
    rd(3'd1, d); check("R9 event beats clear", d, 8'h05);
    lowBatt = 1'b0;
    wr(3'd4, 8'h04);
    rd(3'd1, d); check("R9 clear after event ends", d, 8'h01);
    wakePin = 1'b0;

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule